// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block puts one scan cell beside each output line that runs from the core logic to a device pin. It links the cells into one serial shift path from a serial input to a serial output. In normal mode the chain adds nothing to the path: each core signal reaches its pin unchanged. In test mode a tester can do three things. It can sample every line into the chain in parallel. It can move that snapshot out one bit per test clock while a new pattern moves in. It can then commit the new pattern to a held stage, whose bits drive the pins in place of the core.

A separate test-port controller drives the capture, shift, update and mode strobes. All of them are sampled on the rising edge of the test clock, which also clocks the whole chain. The serial output is retimed onto the falling edge. A downstream chain therefore samples it half a period later, on its own rising edge.

Top module: `bscan_chain`

## Requirements
- R1: While the registered mode is normal, `pin_out[i]` equals `func_in[i]` for every cell i, combinationally.
- R2: `test_mode` is sampled on the rising edge. From the clock after it is sampled high, `pin_out` equals the held update stage. Before that edge, `pin_out` still follows `func_in`.
- R3: With `capture_en` high at a rising edge, the shift stage of cell i loads `func_in[i]`.
- R4: With `shift_en` high and `capture_en` low at a rising edge, cell 0 loads `sdi` and cell i loads the old value of cell i-1. Bits therefore leave in the order cell N-1 first. A word shifted in starting with its bit N-1 ends up with bit i in cell i.
- R5: When `capture_en` and `shift_en` are both high at the same edge, the capture is performed and the shift is not.
- R6: With `update_en` high at a rising edge, the update stage loads the whole shift stage. At every other edge it holds, including while shifting.
- R7: `sdo` presents the shift stage of cell N-1 through a flop clocked on the falling edge. After a rising edge that changes that cell, `sdo` keeps its old value until the next falling edge.
- R8: A synchronous active-high reset clears all shift stages, all update stages and `sdo` to 0, and selects normal mode.
- R9: At a rising edge with neither `capture_en` nor `shift_en` high, the shift stage keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Selects the held update stage onto the pins (registered) |
| capture_en | input | 1 | Parallel capture strobe |
| shift_en | input | 1 | Serial shift strobe |
| update_en | input | 1 | Shift-to-update transfer strobe |
| sdi | input | 1 | Serial data in, enters cell 0 |
| func_in | input | N_CELLS | Functional values from the core |
| pin_out | output | N_CELLS | Values driven toward the pins |
| sdo | output | 1 | Serial data out, from cell N-1, changes on the falling edge |

## Verification
The bench builds the chain with N_CELLS = 8. At that length a whole capture-and-shift round trip with eight bits out and eight bits in takes only nine rising edges. The bench runs it for several patterns, including all-ones, all-zeros and patterns with a single bit set at either end of the chain. The short length also lets directed tests reach the cases that need an exact cycle. These include a capture and a shift strobed at the same edge, new data shifted in while the held stage keeps driving the pins, and `sdo` observed between a rising edge and the following falling edge.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2
  } scan_op_e;
endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     test_mode,
  input  logic     capture_en,
  input  logic     shift_en,
  output scan_op_e op,
  output logic     mode_q
);
  // capture wins over shift when both are strobed together
  always_comb begin
    if (capture_en)    op = OP_CAPTURE;
    else if (shift_en) op = OP_SHIFT;
    else               op = OP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= test_mode;
  end

  // R8: reset leaves normal mode selected
  a_r8_mode_reset: assert property (@(posedge clk) rst |=> !mode_q);
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  scan_op_e op,
  input  logic     update_en,
  input  logic     mode,
  input  logic     line_in,
  input  logic     ser_in,
  output logic     ser_out,
  output logic     hold_out,
  output logic     line_out
);
  logic shift_q;
  logic upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= 1'b0;
    end else begin
      case (op)
        OP_CAPTURE: shift_q <= line_in;
        OP_SHIFT:   shift_q <= ser_in;
        default:    shift_q <= shift_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            upd_q <= 1'b0;
    else if (update_en) upd_q <= shift_q;
  end

  assign ser_out  = shift_q;
  assign hold_out = upd_q;
  assign line_out = mode ? upd_q : line_in;

  // R3 / R5: a capture loads the line value even with shift also strobed
  a_r5_capture_wins: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CAPTURE) |=> (shift_q == $past(line_in)));
  // R6: the update stage holds without the update strobe
  a_r6_update_hold: assert property (@(posedge clk) disable iff (rst)
    !update_en |=> $stable(upd_q));
  // R6: the update stage takes the shift stage on the strobe
  a_r6_update_load: assert property (@(posedge clk) disable iff (rst)
    update_en |=> (upd_q == $past(shift_q)));
  // R9: the shift stage holds when idle
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> $stable(shift_q));
  // R8: both stages clear on reset
  a_r8_cell_reset: assert property (@(posedge clk)
    rst |=> (shift_q == 1'b0 && upd_q == 1'b0));
endmodule

// File: rtl/bscan_sdo_retime.sv
module bscan_sdo_retime (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  // R7: at each falling edge the output shows what was sampled at the previous one
  a_r7_falling_retime: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> (q == $past(d)));
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_CELLS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               test_mode,
  input  logic               capture_en,
  input  logic               shift_en,
  input  logic               update_en,
  input  logic               sdi,
  input  logic [N_CELLS-1:0] func_in,
  output logic [N_CELLS-1:0] pin_out,
  output logic               sdo
);
  localparam int LAST = N_CELLS - 1;

  scan_op_e           op;
  logic               mode_q;
  logic [N_CELLS-1:0] ser_vec;
  logic [N_CELLS-1:0] hold_vec;
  logic [N_CELLS:0]   link;

  bscan_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .test_mode  (test_mode),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .op         (op),
    .mode_q     (mode_q)
  );

  assign link[0] = sdi;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    bscan_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .op        (op),
      .update_en (update_en),
      .mode      (mode_q),
      .line_in   (func_in[i]),
      .ser_in    (link[i]),
      .ser_out   (ser_vec[i]),
      .hold_out  (hold_vec[i]),
      .line_out  (pin_out[i])
    );
    assign link[i+1] = ser_vec[i];
  end

  bscan_sdo_retime u_retime (
    .clk (clk),
    .rst (rst),
    .d   (link[N_CELLS]),
    .q   (sdo)
  );

  // R1: in normal mode the pins follow the core
  a_r1_transparent: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> (pin_out == func_in));
  // R2: once test mode is registered, the pins show the held stage
  a_r2_test_drive: assert property (@(posedge clk) disable iff (rst)
    (test_mode && !update_en) |=> (pin_out == $past(hold_vec)));
  // R4: a plain shift loads sdi into the entry cell
  a_r4_entry: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !capture_en) |=> (ser_vec[0] == $past(sdi)));
  // R4: a plain shift moves the second-to-last cell into the exit cell
  a_r4_exit: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !capture_en) |=> (ser_vec[LAST] == $past(link[LAST])));
endmodule

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;
  localparam int N = 8;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  // each entry: {captured pattern, word shifted in}
  localparam logic [2*N-1:0] VEC [NVEC] = '{
    {8'hA5, 8'h3C}, {8'hFF, 8'h00}, {8'h01, 8'h80}, {8'h5A, 8'hC3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic test_mode = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, sdi = 1'b0;
  logic [N-1:0] func_in = '0;
  logic [N-1:0] pin_out;
  logic sdo;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bscan_chain #(.N_CELLS(N)) u_bscan_chain (
    .clk(clk), .rst(rst), .test_mode(test_mode), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .sdi(sdi),
    .func_in(func_in), .pin_out(pin_out), .sdo(sdo)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic fall();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    // R8 reset state
    test_mode = 1'b0; func_in = 8'h96;
    repeat (3) tick();
    chk("R8 pins follow core under reset", pin_out, 8'h96);
    fall();
    chk("R8 sdo cleared", sdo, 1'b0);
    rst = 1'b0;
    tick();
    func_in = 8'h3B;
    #1 chk("R1 combinational pass-through", pin_out, 8'h3B);

    // R2: mode is registered; update stage is still cleared
    test_mode = 1'b1;
    #1 chk("R2 mode not yet applied", pin_out, 8'h3B);
    tick();
    chk("R2/R8 held stage cleared on pins", pin_out, 8'h00);

    // table: capture, shift out while shifting in, update
    for (int v = 0; v < NVEC; v++) begin
      logic [N-1:0] pat;
      logic [N-1:0] w;
      logic [N-1:0] got;
      logic [N-1:0] want;
      pat = VEC[v][2*N-1:N];
      w   = VEC[v][N-1:0];
      func_in = pat; capture_en = 1'b1;
      tick();
      capture_en = 1'b0;
      fall();
      got = '0; want = '0;
      got[N-1] = sdo; want[N-1] = pat[N-1];
      for (int j = 0; j < N; j++) begin
        sdi = w[N-1-j]; shift_en = 1'b1;
        tick();
        shift_en = 1'b0;
        fall();
        if (j < N-1) begin
          got[N-2-j] = sdo; want[N-2-j] = pat[N-2-j];
        end else begin
          chk("R4 first bit in reaches exit cell", sdo, w[N-1]);
        end
      end
      chk("R3/R4/R7 captured stream out", got, want);
      update_en = 1'b1;
      tick();
      update_en = 1'b0;
      chk("R6/R2 update drives pins", pin_out, w);
    end

    // R5: capture over shift; last held word is C3, bit 6 is 1
    func_in = 8'h00; capture_en = 1'b1; shift_en = 1'b1; sdi = 1'b1;
    tick();
    capture_en = 1'b0; shift_en = 1'b0;
    fall();
    chk("R5 capture wins over shift", sdo, 1'b0);

    // R7: sdo changes only on the falling edge
    func_in = 8'h80; capture_en = 1'b1;
    tick();
    capture_en = 1'b0;
    chk("R7 sdo unchanged before falling edge", sdo, 1'b0);
    fall();
    chk("R7 sdo updated after falling edge", sdo, 1'b1);

    // R9: idle edges keep the shift stage
    func_in = 8'h00;
    repeat (3) tick();
    fall();
    chk("R9 shift stage holds when idle", sdo, 1'b1);

    // R6: shifting without update leaves pins unchanged
    sdi = 1'b0;
    for (int k = 0; k < 3; k++) begin
      shift_en = 1'b1;
      tick();
    end
    shift_en = 1'b0;
    chk("R6 held stage stable while shifting", pin_out, 8'hC3);

    // R1: leaving test mode returns pins to the core
    test_mode = 1'b0; func_in = 8'h5E;
    tick();
    chk("R1 normal mode after exit", pin_out, 8'h5E);

    // R8: reset in test mode clears everything
    test_mode = 1'b1; rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    tick();
    chk("R8 update stage cleared by reset", pin_out, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule